// File: doc/BRIEF.md
# Frame-Synchronized Serial Word Receiver

The receiver takes a serial stream made of three lines: a source clock, a frame-sync line and a data line. It rebuilds 16-bit words from them. The block runs on a fast system clock and oversamples the serial clock. A falling edge of the serial clock captures both the data line and the sync line. A sync rising edge, meaning a 0-to-1 change between two falling-edge samples, marks the start of a frame. The falling edge at which that change is first seen counts as edge 1 of the frame. The first data bit is the most significant one, and it is captured at the third falling edge, which follows the second rising edge. Each later falling edge captures one more bit.

A frame is complete once the next sync rising edge has been detected. The receiver then waits for the second rising serial-clock edge after that detection and presents the frame. In word mode a frame holds 16 bits and appears on a word output with a one-cycle valid strobe. In byte mode a frame holds 8 bits and appears on a byte output with its own strobe. A flag on that output marks the high byte and the low byte, which alternate starting with the high byte.

A line-enable input reports whether the serial lines are driven. When it drops, any partial frame is thrown away and the receiver hunts again for a fresh sync rising edge. The mode input is captured at the sync that ends the hunt.

The control is a three-state machine:
- HUNT waits for a sync rising edge.
- LEAD skips the two lead-in rising edges of the first frame.
- DATA captures bits continuously and presents each frame at its latch point.

The transitions are:
- HUNT→LEAD on a sync rising edge.
- LEAD→DATA on the second rising edge.
- Any state→HUNT when line-enable is low.

Top module: `fsync_word_rx`

## Requirements
- R1: Data bits are captured only on falling edges of `ser_clk`, most significant bit first, and the sync line is sampled on the same edges.
- R2: After reset, and after every low period of `line_en`, no strobe is issued until the sync line is seen going 0 to 1 between two falling-edge samples. A sync line that is already high does not start reception.
- R3: Counting the sync-detect falling edge as 1, the first frame's most significant bit is the one captured at falling edge 3, after the second rising edge.
- R4: In word mode (`byte_mode` = 0 at the start of reception), each 16-bit frame appears on `word_data`. `word_vld` rises in the system cycle after the second rising serial edge that follows the next sync detection.
- R5: In byte mode (`byte_mode` = 1 at the start of reception), each 8-bit frame appears on `byte_data` with `byte_vld`. `byte_hi` is 1 at the first latch point after a hunt and inverts at every later latch point.
- R6: `byte_mode` is sampled only at the sync rising edge that ends the hunt. Changes made later have no effect until the next hunt.
- R7: When `line_en` is low, serial edges are ignored and the partial frame is dropped. No strobe occurs in the following cycle, the state returns to HUNT and the byte flag restarts at high.
- R8: If the number of bits captured since the previous latch point differs from the frame width when a latch point arrives, that frame is dropped without a strobe. Reception continues with the next frame.
- R9: `word_vld` and `byte_vld` are never high together, and each lasts exactly one system cycle.
- R10: After reset, `word_vld` and `byte_vld` are low and no frame is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial source clock, synchronous to `clk` |
| ser_sync | input | 1 | Frame-sync line |
| ser_data | input | 1 | Serial data line |
| line_en | input | 1 | High while the serial lines are driven |
| byte_mode | input | 1 | 1 selects 8-bit frames, 0 selects 16-bit frames |
| word_data | output | WORD_W | Last received word |
| word_vld | output | 1 | One-cycle strobe for `word_data` |
| byte_data | output | WORD_W/2 | Last received byte |
| byte_vld | output | 1 | One-cycle strobe for `byte_data` |
| byte_hi | output | 1 | 1 when `byte_data` is a high byte |

## Verification
The properties assume the following about the inputs:
- The serial clock stays high and low for at least two system cycles each, so every serial edge is seen exactly once.
- All serial lines are already synchronous to the system clock.
- Data and sync change only together with a rising serial edge, so they are stable at each falling edge.

The stimulus meets these assumptions by driving each serial period as two high and two low system cycles and changing data and sync only on the high phase. Line-enable and mode are changed only at period boundaries. The one deliberate exception is a mode flip in the middle of a stream, which exercises the rule that the mode is captured once per hunt.

// File: rtl/fsync_rx_pkg.sv
package fsync_rx_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_LEAD = 2'd1,
        ST_DATA = 2'd2
    } rx_state_e;

endpackage

// File: rtl/fsync_edge_det.sv
// Detects serial clock edges in the system clock domain and the sync
// line's 0-to-1 change between successive falling-edge samples.
module fsync_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_sync,
    input  logic line_en,
    output logic rise_ev,
    output logic fall_ev,
    output logic sync_rise
);

    logic sclk_q;
    logic sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            sync_q <= 1'b1;
        end else begin
            sclk_q <= ser_clk;
            if (!line_en) begin
                sync_q <= 1'b1;
            end else if (fall_ev) begin
                sync_q <= ser_sync;
            end
        end
    end

    assign rise_ev   = line_en &  ser_clk & ~sclk_q;
    assign fall_ev   = line_en & ~ser_clk &  sclk_q;
    assign sync_rise = fall_ev & ser_sync & ~sync_q;

endmodule

// File: rtl/fsync_shreg.sv
// MSB-first shift register with a saturating count of captured bits.
module fsync_shreg #(
    parameter int WIDTH = 16,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] bits_o,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_o  <= '0;
            count_o <= '0;
        end else if (clr) begin
            count_o <= '0;
        end else if (shift_en) begin
            bits_o <= {bits_o[WIDTH-2:0], bit_in};
            if (count_o != CNT_MAX) begin
                count_o <= count_o + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fsync_word_rx.sv
module fsync_word_rx
    import fsync_rx_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ser_clk,
    input  logic                  ser_sync,
    input  logic                  ser_data,
    input  logic                  line_en,
    input  logic                  byte_mode,
    output logic [WORD_W-1:0]     word_data,
    output logic                  word_vld,
    output logic [WORD_W/2-1:0]   byte_data,
    output logic                  byte_vld,
    output logic                  byte_hi
);

    localparam int BYTE_W = WORD_W / 2;
    localparam int CNT_W  = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] WORD_CNT = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] BYTE_CNT = CNT_W'(BYTE_W);

    rx_state_e         state_q, state_d;
    logic              rise_ev, fall_ev, sync_rise;
    logic [1:0]        ridx_q;
    logic              pend_q;
    logic              mode_q;
    logic              hi_q;
    logic              latch_ev;
    logic              frame_ok;
    logic              sh_clr;
    logic              sh_en;
    logic [WORD_W-1:0] sh_bits;
    logic [CNT_W-1:0]  sh_cnt;
    logic [CNT_W-1:0]  need_cnt;

    fsync_edge_det u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk   (ser_clk),
        .ser_sync  (ser_sync),
        .line_en   (line_en),
        .rise_ev   (rise_ev),
        .fall_ev   (fall_ev),
        .sync_rise (sync_rise)
    );

    assign latch_ev = (state_q == ST_DATA) & rise_ev & pend_q & (ridx_q == 2'd1);
    assign need_cnt = mode_q ? BYTE_CNT : WORD_CNT;
    assign frame_ok = latch_ev & (sh_cnt == need_cnt);
    assign sh_clr   = (state_q != ST_DATA) | latch_ev;
    assign sh_en    = (state_q == ST_DATA) & fall_ev;

    fsync_shreg #(
        .WIDTH (WORD_W),
        .CNT_W (CNT_W)
    ) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (sh_clr),
        .shift_en (sh_en),
        .bit_in   (ser_data),
        .bits_o   (sh_bits),
        .count_o  (sh_cnt)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!line_en) begin
            state_d = ST_HUNT;
        end else begin
            unique case (state_q)
                ST_HUNT: if (sync_rise) state_d = ST_LEAD;
                ST_LEAD: if (rise_ev && ridx_q == 2'd1) state_d = ST_DATA;
                ST_DATA: state_d = ST_DATA;
                default: state_d = ST_HUNT;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // Frame bookkeeping: edge index since sync, pending frame, mode, byte phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ridx_q <= 2'd0;
            pend_q <= 1'b0;
            mode_q <= 1'b0;
            hi_q   <= 1'b1;
        end else if (!line_en) begin
            ridx_q <= 2'd0;
            pend_q <= 1'b0;
            hi_q   <= 1'b1;
        end else begin
            unique case (state_q)
                ST_HUNT: begin
                    pend_q <= 1'b0;
                    hi_q   <= 1'b1;
                    if (sync_rise) begin
                        ridx_q <= 2'd0;
                        mode_q <= byte_mode;
                    end
                end
                ST_LEAD: begin
                    if (rise_ev && ridx_q != 2'd3) ridx_q <= ridx_q + 2'd1;
                end
                ST_DATA: begin
                    if (sync_rise) begin
                        ridx_q <= 2'd0;
                        pend_q <= 1'b1;
                    end else if (rise_ev) begin
                        if (ridx_q != 2'd3) ridx_q <= ridx_q + 2'd1;
                        if (latch_ev) begin
                            pend_q <= 1'b0;
                            if (mode_q) hi_q <= ~hi_q;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_data <= '0;
            word_vld  <= 1'b0;
            byte_data <= '0;
            byte_vld  <= 1'b0;
            byte_hi   <= 1'b0;
        end else begin
            word_vld <= frame_ok & ~mode_q;
            byte_vld <= frame_ok &  mode_q;
            if (frame_ok && !mode_q) begin
                word_data <= sh_bits;
            end
            if (frame_ok && mode_q) begin
                byte_data <= sh_bits[BYTE_W-1:0];
                byte_hi   <= hi_q;
            end
        end
    end

endmodule

// File: rtl/fsync_word_rx_chk.sv
module fsync_word_rx_chk
    import fsync_rx_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      line_en,
    input logic      word_vld,
    input logic      byte_vld,
    input rx_state_e state_q
);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_vld && byte_vld)); // R9

    AST_WORD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld); // R9

    AST_BYTE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld); // R9

    AST_EN_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !line_en |=> (!word_vld && !byte_vld)); // R7

    AST_EN_LOW_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !line_en |=> (state_q == ST_HUNT)); // R7

    AST_HUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HUNT) |=> (!word_vld && !byte_vld)); // R2

endmodule

bind fsync_word_rx fsync_word_rx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_en  (line_en),
    .word_vld (word_vld),
    .byte_vld (byte_vld),
    .state_q  (state_q)
);

// File: tb/test_fsync_word_rx.sv
module test_fsync_word_rx;

    localparam int WW = 16;
    localparam int BW = WW / 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ser_clk = 1'b0;
    logic          ser_sync = 1'b0;
    logic          ser_data = 1'b0;
    logic          line_en = 1'b0;
    logic          byte_mode = 1'b0;
    logic [WW-1:0] word_data;
    logic          word_vld;
    logic [BW-1:0] byte_data;
    logic          byte_vld;
    logic          byte_hi;

    int    checks = 0;
    int    fails = 0;
    int    act_w = 0;
    int    act_b = 0;
    string cur_req = "R10";

    // behavioural reference state
    bit    m_prev_clk = 1'b0;
    bit    m_sync_prev = 1'b1;
    int    m_st = 0;          // 0 waiting for sync, 1 lead-in, 2 receiving
    int    m_rc = 0;
    bit    m_pend = 1'b0;
    bit    m_mode = 1'b0;
    bit    m_hi = 1'b1;
    bit    m_q[$];
    bit    exp_wv = 1'b0;
    bit    exp_bv = 1'b0;
    bit    exp_bh = 1'b0;
    int    exp_wd = 0;
    int    exp_bd = 0;

    always #2ns clk = ~clk;

    fsync_word_rx #(.WORD_W(WW)) i_fsync_word_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk   (ser_clk),
        .ser_sync  (ser_sync),
        .ser_data  (ser_data),
        .line_en   (line_en),
        .byte_mode (byte_mode),
        .word_data (word_data),
        .word_vld  (word_vld),
        .byte_data (byte_data),
        .byte_vld  (byte_vld),
        .byte_hi   (byte_hi)
    );

    task automatic chk(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", cur_req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    task automatic model_step(bit sc, bit s, bit d, bit en, bit bm);
        bit rise, fall, srise;
        int w, wid;
        rise = sc && !m_prev_clk;
        fall = !sc && m_prev_clk;
        m_prev_clk = sc;
        exp_wv = 1'b0;
        exp_bv = 1'b0;
        if (!en || !rst_n) begin
            m_st = 0; m_sync_prev = 1'b1; m_pend = 1'b0; m_hi = 1'b1;
            m_q.delete();
            return;
        end
        if (fall) begin
            srise = s && !m_sync_prev;
            m_sync_prev = s;
            if (m_st == 0 && srise) begin
                m_st = 1; m_rc = 0; m_mode = bm;
            end else if (m_st == 2) begin
                m_q.push_back(d);
                if (srise) begin m_pend = 1'b1; m_rc = 0; end
            end
        end
        if (rise && m_st == 1) begin
            m_rc++;
            if (m_rc == 2) begin m_st = 2; m_q.delete(); end
        end else if (rise && m_st == 2) begin
            m_rc++;
            if (m_rc == 2 && m_pend) begin
                m_pend = 1'b0;
                wid = m_mode ? BW : WW;
                if (m_q.size() == wid) begin
                    w = 0;
                    foreach (m_q[i]) w = (w << 1) | int'(m_q[i]);
                    if (m_mode) begin exp_bv = 1'b1; exp_bd = w; exp_bh = m_hi; end
                    else begin exp_wv = 1'b1; exp_wd = w; end
                end
                m_q.delete();
                if (m_mode) m_hi = !m_hi;
            end
        end
    endtask

    // compare last cycle's outputs, then drive and advance the model
    task automatic tick(bit sc, bit s, bit d);
        @(negedge clk);
        chk("word_vld", int'(word_vld), int'(exp_wv));
        chk("byte_vld", int'(byte_vld), int'(exp_bv));
        if (exp_wv && word_vld) chk("word_data", int'(word_data), exp_wd);
        if (exp_bv && byte_vld) begin
            chk("byte_data", int'(byte_data), exp_bd);
            chk("byte_hi", int'(byte_hi), int'(exp_bh));
        end
        if (word_vld) act_w++;
        if (byte_vld) act_b++;
        ser_clk = sc; ser_sync = s; ser_data = d;
        model_step(sc, s, d, line_en, byte_mode);
    endtask

    task automatic sper(bit s, bit d);
        tick(1'b1, s, d); tick(1'b1, s, d);
        tick(1'b0, s, d); tick(1'b0, s, d);
    endtask

    task automatic rehunt();
        line_en = 1'b0;
        for (int i = 0; i < 4; i++) tick(1'b0, 1'b0, 1'b0);
        line_en = 1'b1;
    endtask

    // n frames of width wid; optional mode flip at period flip_at
    task automatic send_frames(int wid, int n, int words[$], int flip_at);
        int idx;
        bit d, s;
        sper(1'b0, 1'b0); sper(1'b0, 1'b0);
        for (int p = 0; p <= n * wid + 2; p++) begin
            if (p == flip_at) byte_mode = ~byte_mode;
            s = (p % wid == 0) && (p <= n * wid);
            idx = p - 2;
            d = 1'b0;
            if (idx >= 0 && idx / wid < n) d = words[idx / wid][wid - 1 - idx % wid];
            sper(s, d);
        end
    endtask

    initial begin
        #800us;
        fails++;
        $display("FAIL watchdog act=%0d exp=%0d", checks, 0);
        summary();
        $finish;
    end

    initial begin
        int base;
        int words[$];
        int syncs[$];
        bit s;
        // R10: reset state
        cur_req = "R10";
        for (int i = 0; i < 4; i++) tick(1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, 1'b0);
        chk("R10 strobes after reset", act_w + act_b, 0);

        // R2: sync held high from the start never begins a frame
        cur_req = "R2";
        line_en = 1'b1;
        for (int i = 0; i < 20; i++) sper(1'b1, 1'($urandom()));
        chk("R2 strobes with sync stuck high", act_w + act_b, 0);

        // R1 R3 R4: word frames with distinct patterns
        cur_req = "R1 R3 R4";
        base = act_w;
        words = '{16'hA55A, 16'hFFFF, 16'h0001, 16'h8000, 16'h3C96};
        send_frames(WW, 5, words, -1);
        chk("R4 word count", act_w - base, 5);

        // R7: enable drop mid-frame discards the partial frame
        cur_req = "R7";
        rehunt();
        base = act_w;
        sper(1'b0, 1'b0); sper(1'b0, 1'b0);
        sper(1'b1, 1'b0); sper(1'b0, 1'b0);
        for (int i = 0; i < 8; i++) sper(1'b0, 1'b1);
        line_en = 1'b0;
        for (int i = 0; i < 6; i++) tick(1'b0, 1'b0, 1'b0);
        chk("R7 strobes after drop", act_w - base, 0);
        line_en = 1'b1;
        words = '{16'h1234, 16'hFEDC};
        send_frames(WW, 2, words, -1);
        chk("R7 words after resume", act_w - base, 2);

        // R5: byte mode, alternating high/low flag
        cur_req = "R5";
        rehunt();
        byte_mode = 1'b1;
        base = act_b;
        words = '{8'hC3, 8'h5A, 8'h01, 8'h80, 8'hFF, 8'h7E};
        send_frames(BW, 6, words, -1);
        chk("R5 byte count", act_b - base, 6);

        // R6: mode flip mid-stream has no effect until re-hunt
        cur_req = "R6";
        rehunt();
        base = act_b;
        words = '{8'h11, 8'h22, 8'h33, 8'h44};
        send_frames(BW, 4, words, 10);
        chk("R6 bytes despite mode flip", act_b - base, 4);
        rehunt();
        base = act_w;
        words = '{16'hBEEF};
        send_frames(WW, 1, words, -1);
        chk("R6 new mode after re-hunt", act_w - base, 1);

        // R8: misplaced sync drops one frame only
        cur_req = "R8";
        rehunt();
        base = act_w;
        syncs = '{0, 16, 28, 44, 60};
        sper(1'b0, 1'b0); sper(1'b0, 1'b0);
        for (int p = 0; p <= 62; p++) begin
            s = 1'b0;
            foreach (syncs[k]) if (syncs[k] == p) s = 1'b1;
            sper(s, 1'($urandom()));
        end
        chk("R8 words with one short frame", act_w - base, 3);

        // R9: strobes never overlap (also checked every cycle above)
        cur_req = "R9";
        for (int i = 0; i < 4; i++) tick(1'b0, 1'b0, 1'b0);
        chk("R9 total strobes", act_w + act_b, 5 + 2 + 6 + 4 + 1 + 3);

        summary();
        $finish;
    end

endmodule